// File: doc/BRIEF.md
# Serial Baud Rate Clock Generator

This block derives two timing strobes for an asynchronous serial port from the processor clock. One is a receive sampling strobe. The other is a transmit bit strobe that fires once per sixteen sampling strobes. No derived clocks are made. Every stage is a counter that runs on the processor clock and emits a one-cycle enable pulse, and the next stage counts those pulses.

Software sets the rate through one 8-bit control register. A 2-bit prescale field picks a divisor of 1, 3, 4 or 13. A 3-bit rate field then divides the prescaled stream by a power of two. A write to the register restarts every counter, so the new rate starts from a known phase.

Reset returns the prescale field to divide-by-one. It leaves the rate field as it was, so the rate field holds an unknown value after power-up until software writes it.

Top module: `baud_tick_gen`

## Requirements
- R1: The prescale field sits in register bits 5:4. Value 0 divides the processor clock by 1, value 1 by 3, value 2 by 4 and value 3 by 13. Call that divisor P.
- R2: The rate field sits in register bits 2:0. Value N gives receive sampling strobes exactly D = P * 2^N processor cycles apart, for every N from 0 to 7.
- R3: The transmit bit strobe fires exactly once per 16 sampling strobes, one cycle after the sampling strobe that completes each group of 16.
- R4: A register write restarts all counters. Count the edge that samples the write as edge 0. The first sampling strobe is then high after edge D+1, and the first bit strobe is high after edge 16*D+2. Neither strobe is high in the cycle right after the write edge.
- R5: While reset is high, both strobes are low. Reset sets the prescale field to 0, and a write presented during reset is ignored.
- R6: Reset does not change the rate field, which keeps its last written value.
- R7: rd_data returns the register as {2'b00, prescale, 1'b0, rate}. Bits 7, 6 and 3 always read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register contents |
| samp_tick | output | 1 | Receive sampling strobe, one cycle wide |
| bit_tick | output | 1 | Transmit bit strobe, one cycle wide |

## Verification
The hardest case to reach is the slowest rate: prescale 13 with rate 7. A single bit period there takes 26,624 cycles. Sweeping all 32 settings while also waiting for a second bit period would cost far more cycles. To avoid this, the bench times every strobe from a register write. That write restarts the chain at a known phase, so the gap from write to first bit strobe is an exact value. The bench then measures 16 sampling gaps and one bit gap for each setting, and each setting's write lands while the previous setting's chain is still running. This also covers the restart behaviour. Reset behaviour is checked by writing a known rate, pulsing reset and reading the register back.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int REG_W      = 8;
  localparam int PRE_W      = 2;
  localparam int PRE_LSB    = 4;
  localparam int PRE_CNT_W  = 4;

  // Prescale code to terminal count (divisor minus one): 1, 3, 4, 13.
  function automatic logic [PRE_CNT_W-1:0] pre_limit(input logic [PRE_W-1:0] code);
    case (code)
      2'd0:    pre_limit = PRE_CNT_W'(0);
      2'd1:    pre_limit = PRE_CNT_W'(2);
      2'd2:    pre_limit = PRE_CNT_W'(3);
      default: pre_limit = PRE_CNT_W'(12);
    endcase
  endfunction
endpackage

// File: rtl/tick_stage.sv
module tick_stage #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             en,
  input  logic [CNT_W-1:0] lim,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (en) begin
      if (cnt >= lim) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    tick |-> ($past(en) && !$past(restart))); // R2
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim); // R2
endmodule

// File: rtl/baud_reg.sv
module baud_reg
  import baud_pkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [PRE_W-1:0]  pre_sel,
  output logic [RATE_W-1:0] rate_sel,
  output logic [REG_W-1:0]  rd_data
);
  // Prescale field: cleared by reset.
  always_ff @(posedge clk) begin
    if (rst)        pre_sel <= '0;
    else if (wr_en) pre_sel <= wr_data[PRE_LSB +: PRE_W];
  end

  // Rate field: deliberately untouched by reset.
  always_ff @(posedge clk) begin
    if (!rst && wr_en) rate_sel <= wr_data[RATE_W-1:0];
  end

  always_comb begin
    rd_data = '0;
    rd_data[PRE_LSB +: PRE_W] = pre_sel;
    rd_data[RATE_W-1:0]       = rate_sel;
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int RATE_W     = 3,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             samp_tick,
  output logic             bit_tick
);
  localparam int RATE_CNT_W = (1 << RATE_W) - 1;
  localparam int OS_CNT_W   = $clog2(OVERSAMPLE);

  logic [PRE_W-1:0]      pre_sel;
  logic [RATE_W-1:0]     rate_sel;
  logic [PRE_CNT_W-1:0]  pre_lim;
  logic [RATE_CNT_W-1:0] rate_lim;
  logic                  pre_tick;
  logic                  restart;

  assign restart  = wr_en;
  assign pre_lim  = pre_limit(pre_sel);
  assign rate_lim = ~({RATE_CNT_W{1'b1}} << rate_sel);

  baud_reg #(.RATE_W(RATE_W)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pre_sel(pre_sel), .rate_sel(rate_sel), .rd_data(rd_data)
  );

  tick_stage #(.CNT_W(PRE_CNT_W)) u_pre (
    .clk(clk), .rst(rst), .restart(restart), .en(1'b1),
    .lim(pre_lim), .tick(pre_tick)
  );

  tick_stage #(.CNT_W(RATE_CNT_W)) u_rate (
    .clk(clk), .rst(rst), .restart(restart), .en(pre_tick),
    .lim(rate_lim), .tick(samp_tick)
  );

  tick_stage #(.CNT_W(OS_CNT_W)) u_os (
    .clk(clk), .rst(rst), .restart(restart), .en(samp_tick),
    .lim(OS_CNT_W'(OVERSAMPLE - 1)), .tick(bit_tick)
  );

  AST_BIT_FOLLOWS_SAMP: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> $past(samp_tick)); // R3
  AST_QUIET_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> (!samp_tick && !bit_tick)); // R4
  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    rst |=> (!samp_tick && !bit_tick)); // R5
  AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data[PRE_LSB +: PRE_W] == '0)); // R5
  AST_RATE_HELD: assert property (@(posedge clk)
    rst |=> (rd_data[RATE_W-1:0] == $past(rd_data[RATE_W-1:0]))); // R6
  AST_SPARE_ZERO: assert property (@(posedge clk)
    (rd_data[7:6] == 2'b00) && !rd_data[3]); // R7
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       samp_tick, bit_tick;

  int checks = 0;
  int failures = 0;
  int edge_no = 0;
  int last_samp = 0;
  int last_bit = 0;
  int sq[$];
  int bq[$];
  bit done = 1'b0;

  baud_tick_gen uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .samp_tick(samp_tick), .bit_tick(bit_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edge_no <= edge_no + 1;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, got, exp, edge_no);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Monitor: compares strobe gaps against expected items from the driver.
  always @(negedge clk) begin
    if (samp_tick && sq.size() > 0) begin
      int e;
      e = sq.pop_front();
      check("R1/R2/R4 samp gap", edge_no - last_samp, e);
      last_samp = edge_no;
    end
    if (bit_tick && bq.size() > 0) begin
      int e;
      e = bq.pop_front();
      check("R3/R4 bit gap", edge_no - last_bit, e);
      last_bit = edge_no;
    end
  end

  function automatic int pre_div(input int code);
    case (code)
      0: return 1;
      1: return 3;
      2: return 4;
      default: return 13;
    endcase
  endfunction

  // Driver: write one setting and queue the expected strobe gaps.
  task automatic run_combo(input int p, input int n);
    int d;
    d = pre_div(p) * (1 << n);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'((p << 4) | n);
    @(negedge clk);
    wr_en = 1'b0;
    last_samp = edge_no;
    last_bit  = edge_no;
    sq.push_back(d + 1);
    for (int k = 1; k < 16; k++) sq.push_back(d);
    bq.push_back(16 * d + 2);
    while (bq.size() > 0) @(negedge clk);
    sq.delete();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", edge_no);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R5 samp low in reset", int'(samp_tick), 0);
    check("R5 bit low in reset", int'(bit_tick), 0);
    check("R5 prescale cleared", int'(rd_data[5:4]), 0);
    rst = 1'b0;

    write_reg(8'hFF);
    check("R7 spare bits zero", int'(rd_data), 8'h37);
    write_reg(8'h25);
    check("R7 readback", int'(rd_data), 8'h25);

    // Reset: prescale clears, rate kept, write during reset ignored.
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_data = 8'h33;
    @(negedge clk);
    wr_en = 1'b0;
    check("R5 samp low in reset", int'(samp_tick), 0);
    check("R5 bit low in reset", int'(bit_tick), 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R5 prescale after reset", int'(rd_data[5:4]), 0);
    check("R6 rate kept over reset", int'(rd_data[2:0]), 5);
    check("R7 readback after reset", int'(rd_data), 8'h05);

    // Sweep all 32 settings; each write lands on a running chain.
    for (int p = 0; p < 4; p++)
      for (int n = 0; n < 8; n++)
        run_combo(p, n);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule